// File: doc/BRIEF.md
# Power-down clock gating controller

This block decides whether the serial-bus clocks and the two serial data lines stay alive while the device is powered down. A free-running frame timer, clocked by the oscillator, produces the data clock and the bit clock. When power-down is requested and the clock-freeze setting is on, the block stops both clocks at the next frame boundary. It then holds them low and forces both data lines to their high idle level. When the clock-freeze setting is off, a power-down request leaves the clocks running.

Wake-up can come from either side. Line activity reported by the level detector during power-down either restarts the clocks by itself or only raises a latched interrupt flag. The auto-wake-disable setting chooses between the two. From the local side, the controller wakes the clocks by clearing the freeze setting. It can also set and then clear a power-up bit and then write the timing command code. A restart also waits for a frame boundary, so the enables never change while a gated clock is high.

Top module: `pwrdn_clkgate`

## Requirements
- R1: After reset both clock enables are 1, both data-line idle outputs are 0 and the activity interrupt flag is 0.
- R2: With `freeze_cfg` = 0, a `pd_req` pulse has no effect and the clocks keep running.
- R3: With `freeze_cfg` = 1, a `pd_req` pulse seen at edge p drops both enables at the first frame boundary after p. A frame is FRAME_LEN (32) oscillator cycles, and boundaries fall every FRAME_LEN edges counted from reset release.
- R4: The clock enables change only on a frame boundary, where both gated clocks are low.
- R5: While the enables are 0, `dclk_o` and `bclk_o` stay low and `dn_idle` and `up_idle` are 1.
- R6: With `autowake_off` = 0, a `line_act` pulse during power-down re-enables the clocks at the next frame boundary.
- R7: With `autowake_off` = 1, a `line_act` pulse during power-down leaves the clocks stopped and sets `act_irq` on the next edge.
- R8: `act_irq` stays set until an `irq_rd_clr` strobe clears it. A `line_act` pulse while the clocks run does not set it.
- R9: Local wake during power-down requires three steps in order: `pwrup_bit` goes 1, `pwrup_bit` goes back to 0, then a `cmd_wr` strobe arrives with `cmd_code` = 4'h0. The clocks then restart at the next frame boundary. A code write without that sequence, or with any other code, is ignored.
- R10: Clearing `freeze_cfg` during power-down wakes the clocks at the next frame boundary. Clearing it while a stop is still pending cancels the stop.
- R11: While enabled, `dclk_o` is high during the upper half of each DCL_DIV (4) cycle period and `bclk_o` is high during the upper half of each 2*DCL_DIV cycle period. Both are low at the frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| pd_req | input | 1 | Power-down request pulse |
| freeze_cfg | input | 1 | 1: stop clocks in power-down |
| autowake_off | input | 1 | 1: line activity only raises the interrupt |
| line_act | input | 1 | Level-detect pulse from the line |
| pwrup_bit | input | 1 | Software power-up bit |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | CMD_W | Command code carried by the write |
| irq_rd_clr | input | 1 | Read-to-clear strobe for the interrupt |
| dclk_en | output | 1 | Data clock enable |
| bclk_en | output | 1 | Bit clock enable |
| dclk_o | output | 1 | Gated data clock |
| bclk_o | output | 1 | Gated bit clock |
| dn_idle | output | 1 | Downstream data line forced high |
| up_idle | output | 1 | Upstream data line forced high |
| act_irq | output | 1 | Level-detect interrupt flag |

## Verification
The bench places power-down requests and wake events at various frame offsets. It expects every enable change on exactly the next frame boundary. A design that gated the clocks the moment a request arrived would cut a clock pulse short, and the per-cycle boundary and clock-pattern checks would report it. The wake paths are tried in their negative forms: a code write without the set-clear sequence, a wrong code, and line activity with auto-wake disabled. A design that woke on any of these would show enables returning at the following boundary. The bench also checks that the interrupt flag holds across a full frame until it is cleared, and that a stop still pending is cancelled when the freeze setting is dropped.

// File: rtl/pwrdn_clkgate_pkg.sv
package pwrdn_clkgate_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PEND = 2'd1,
    ST_OFF  = 2'd2,
    ST_WAKE = 2'd3
  } pd_state_t;

  // Data clock level for a frame position: high in upper half of period div
  function automatic logic dclk_level(input int unsigned pos, input int unsigned div);
    return (pos % div) >= (div / 2);
  endfunction

  // Bit clock runs at half the data clock rate
  function automatic logic bclk_level(input int unsigned pos, input int unsigned div);
    return (pos % (2 * div)) >= div;
  endfunction

  // Clocks enabled in these states
  function automatic logic clocks_on(input pd_state_t s);
    return (s == ST_RUN) || (s == ST_PEND);
  endfunction

endpackage

// File: rtl/pwrdn_phase.sv
module pwrdn_phase
  import pwrdn_clkgate_pkg::*;
#(
  parameter int FRAME_LEN = 32,
  parameter int DCL_DIV   = 4
) (
  input  logic clk,
  input  logic rst,
  output logic frame_last,
  output logic frame_start,
  output logic dclk_raw,
  output logic bclk_raw
);
  localparam int CW = $clog2(FRAME_LEN);
  localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

  logic [CW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst)              pos <= '0;
    else if (pos == LAST) pos <= '0;
    else                  pos <= pos + 1'b1;
  end

  assign frame_last  = (pos == LAST);
  assign frame_start = (pos == '0);
  assign dclk_raw    = dclk_level(32'(pos), DCL_DIV);
  assign bclk_raw    = bclk_level(32'(pos), DCL_DIV);
endmodule

// File: rtl/pwrdn_local_wake.sv
module pwrdn_local_wake #(
  parameter int              CMD_W    = 4,
  parameter logic [CMD_W-1:0] TIM_CODE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             off,
  input  logic             pwrup_bit,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_code,
  output logic             wake
);
  logic seen_set;
  logic seen_clr;

  // Sequence tracked only during power-down
  always_ff @(posedge clk) begin
    if (rst || !off) begin
      seen_set <= 1'b0;
      seen_clr <= 1'b0;
    end else if (pwrup_bit) begin
      seen_set <= 1'b1;
      seen_clr <= 1'b0;
    end else if (seen_set) begin
      seen_clr <= 1'b1;
    end
  end

  assign wake = off && seen_clr && cmd_wr && (cmd_code == TIM_CODE);
endmodule

// File: rtl/pwrdn_act_flag.sv
module pwrdn_act_flag (
  input  logic clk,
  input  logic rst,
  input  logic off,
  input  logic line_act,
  input  logic autowake_off,
  input  logic irq_rd_clr,
  output logic act_irq,
  output logic line_wake
);
  logic set_ev;

  assign set_ev    = off && line_act && autowake_off;
  assign line_wake = off && line_act && !autowake_off;

  // Set takes priority over clear
  always_ff @(posedge clk) begin
    if (rst)             act_irq <= 1'b0;
    else if (set_ev)     act_irq <= 1'b1;
    else if (irq_rd_clr) act_irq <= 1'b0;
  end
endmodule

// File: rtl/pwrdn_clkgate.sv
module pwrdn_clkgate
  import pwrdn_clkgate_pkg::*;
#(
  parameter int               FRAME_LEN = 32,
  parameter int               DCL_DIV   = 4,
  parameter int               CMD_W     = 4,
  parameter logic [CMD_W-1:0] TIM_CODE  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pd_req,
  input  logic             freeze_cfg,
  input  logic             autowake_off,
  input  logic             line_act,
  input  logic             pwrup_bit,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             irq_rd_clr,
  output logic             dclk_en,
  output logic             bclk_en,
  output logic             dclk_o,
  output logic             bclk_o,
  output logic             dn_idle,
  output logic             up_idle,
  output logic             act_irq
);
  pd_state_t state;
  pd_state_t state_nx;

  // Named internal events
  logic frame_last_w;
  logic frame_start_w;
  logic dclk_raw;
  logic bclk_raw;
  logic off_w;
  logic run_w;
  logic local_wake_w;
  logic line_wake_w;
  logic wake_any_w;
  logic clk_on_w;

  pwrdn_phase #(
    .FRAME_LEN (FRAME_LEN),
    .DCL_DIV   (DCL_DIV)
  ) u_phase (
    .clk         (clk),
    .rst         (rst),
    .frame_last  (frame_last_w),
    .frame_start (frame_start_w),
    .dclk_raw    (dclk_raw),
    .bclk_raw    (bclk_raw)
  );

  pwrdn_local_wake #(
    .CMD_W    (CMD_W),
    .TIM_CODE (TIM_CODE)
  ) u_lwake (
    .clk       (clk),
    .rst       (rst),
    .off       (off_w),
    .pwrup_bit (pwrup_bit),
    .cmd_wr    (cmd_wr),
    .cmd_code  (cmd_code),
    .wake      (local_wake_w)
  );

  pwrdn_act_flag u_flag (
    .clk          (clk),
    .rst          (rst),
    .off          (off_w),
    .line_act     (line_act),
    .autowake_off (autowake_off),
    .irq_rd_clr   (irq_rd_clr),
    .act_irq      (act_irq),
    .line_wake    (line_wake_w)
  );

  assign off_w      = (state == ST_OFF);
  assign run_w      = (state == ST_RUN);
  assign wake_any_w = local_wake_w || line_wake_w || !freeze_cfg;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:  if (pd_req && freeze_cfg) state_nx = ST_PEND;
      ST_PEND: begin
        if (!freeze_cfg)       state_nx = ST_RUN;
        else if (frame_last_w) state_nx = ST_OFF;
      end
      ST_OFF:  if (wake_any_w)   state_nx = ST_WAKE;
      ST_WAKE: if (frame_last_w) state_nx = ST_RUN;
      default: state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RUN;
    else     state <= state_nx;
  end

  assign clk_on_w = clocks_on(state);
  assign dclk_en  = clk_on_w;
  assign bclk_en  = clk_on_w;
  assign dclk_o   = clk_on_w && dclk_raw;
  assign bclk_o   = clk_on_w && bclk_raw;
  assign dn_idle  = !clk_on_w;
  assign up_idle  = !clk_on_w;
endmodule

// File: rtl/pwrdn_clkgate_chk.sv
module pwrdn_clkgate_chk (
  input logic clk,
  input logic rst,
  input logic pd_req,
  input logic freeze_cfg,
  input logic autowake_off,
  input logic line_act,
  input logic irq_rd_clr,
  input logic dclk_en,
  input logic bclk_en,
  input logic dclk_o,
  input logic bclk_o,
  input logic dn_idle,
  input logic up_idle,
  input logic act_irq,
  input logic off_w,
  input logic run_w,
  input logic frame_start_w
);
  // R4
  en_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(dclk_en) || !$stable(bclk_en)) |-> frame_start_w);

  // R5
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    off_w |-> (!dclk_o && !bclk_o && dn_idle && up_idle));

  // R2
  keep_run_chk: assert property (@(posedge clk) disable iff (rst)
    (run_w && pd_req && !freeze_cfg) |=> dclk_en);

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (off_w && line_act && autowake_off) |=> (act_irq && !dclk_en));

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (act_irq && !irq_rd_clr) |=> act_irq);

  // R6
  line_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (off_w && line_act && !autowake_off) |=> !off_w);

  // R10
  cfg_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (off_w && !freeze_cfg) |=> !off_w);

  // R11
  frame_low_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start_w |-> (!dclk_o && !bclk_o));
endmodule

bind pwrdn_clkgate pwrdn_clkgate_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .pd_req        (pd_req),
  .freeze_cfg    (freeze_cfg),
  .autowake_off  (autowake_off),
  .line_act      (line_act),
  .irq_rd_clr    (irq_rd_clr),
  .dclk_en       (dclk_en),
  .bclk_en       (bclk_en),
  .dclk_o        (dclk_o),
  .bclk_o        (bclk_o),
  .dn_idle       (dn_idle),
  .up_idle       (up_idle),
  .act_irq       (act_irq),
  .off_w         (off_w),
  .run_w         (run_w),
  .frame_start_w (frame_start_w)
);

// File: tb/pwrdn_clkgate_test.sv
module pwrdn_clkgate_test;
  localparam int CLK_T = 10;
  localparam int FRAME = 32;
  localparam int DIV   = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic       pd_req, freeze_cfg, autowake_off, line_act, pwrup_bit, cmd_wr, irq_rd_clr;
  logic [3:0] cmd_code;
  logic       dclk_en, bclk_en, dclk_o, bclk_o, dn_idle, up_idle, act_irq;

  always #(CLK_T/2) clk = ~clk;

  pwrdn_clkgate uut (
    .clk(clk), .rst(rst), .pd_req(pd_req), .freeze_cfg(freeze_cfg),
    .autowake_off(autowake_off), .line_act(line_act), .pwrup_bit(pwrup_bit),
    .cmd_wr(cmd_wr), .cmd_code(cmd_code), .irq_rd_clr(irq_rd_clr),
    .dclk_en(dclk_en), .bclk_en(bclk_en), .dclk_o(dclk_o), .bclk_o(bclk_o),
    .dn_idle(dn_idle), .up_idle(up_idle), .act_irq(act_irq)
  );

  typedef struct {
    int         due;
    int         kind;   // 0: enables/idle, 1: interrupt
    logic [3:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    total = 0;
  int    bad   = 0;
  int    cyc   = 0;
  bit    done  = 0;

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  function automatic int bnd(input int k);
    return (k / FRAME + 1) * FRAME;
  endfunction

  function automatic logic [3:0] en_pat(input logic on);
    return on ? 4'b1100 : 4'b0011;
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%b expected=%b", tag, cyc, act, exp);
    end
  endtask

  task automatic push(input int due, input int kind, input logic [3:0] e, input string tag);
    item_t it;
    if (due > cyc) begin
      it.due = due; it.kind = kind; it.exp = e; it.tag = tag;
      q.push_back(it);
    end
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_pd(output int p);
    @(negedge clk); pd_req = 1'b1; p = cyc + 1;
    @(negedge clk); pd_req = 1'b0;
  endtask

  task automatic pulse_line(output int p);
    @(negedge clk); line_act = 1'b1; p = cyc + 1;
    @(negedge clk); line_act = 1'b0;
  endtask

  task automatic write_code(input logic [3:0] c, output int p);
    @(negedge clk); cmd_wr = 1'b1; cmd_code = c; p = cyc + 1;
    @(negedge clk); cmd_wr = 1'b0; cmd_code = 4'h0;
  endtask

  task automatic go_off(input string tag);
    int p;
    pulse_pd(p);
    push(bnd(p), 0, en_pat(1'b0), tag);
    drain();
  endtask

  // Monitor: scoreboard pops plus per-cycle checks
  logic prev_en = 1'b1;
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_T/4);
      if (!rst && !done) begin
        while (q.size() != 0 && q[0].due <= cyc) begin
          item_t it;
          it = q.pop_front();
          if (it.due < cyc) chk({it.tag, " missed"}, 4'b0, 4'b1);
          else if (it.kind == 0) chk(it.tag, {dclk_en, bclk_en, dn_idle, up_idle}, it.exp);
          else chk(it.tag, {3'b000, act_irq}, it.exp);
        end
        // R4: enable change only at a frame boundary
        if (dclk_en !== prev_en) chk("R4 boundary", 4'(cyc % FRAME), 4'd0);
        prev_en = dclk_en;
        // R5: stopped clocks low, lines idle high
        if (!dclk_en) chk("R5 idle", {dclk_o, bclk_o, dn_idle, up_idle}, 4'b0011);
        // R11: clock waveform while enabled
        if (dclk_en)
          chk("R11 pattern", {2'b00, dclk_o, bclk_o},
              {2'b00, 1'((cyc % DIV) >= DIV/2), 1'((cyc % (2*DIV)) >= DIV)});
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Driver
  initial begin
    int p;
    rst = 1'b1; pd_req = 0; freeze_cfg = 0; autowake_off = 0; line_act = 0;
    pwrup_bit = 0; cmd_wr = 0; cmd_code = 4'h0; irq_rd_clr = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 enables", {dclk_en, bclk_en, dn_idle, up_idle}, 4'b1100);
    chk("R1 irq", {3'b000, act_irq}, 4'b0000);
    rst = 1'b0;

    // R2: freeze off, request ignored
    pulse_pd(p);
    push(bnd(p) + 2, 0, en_pat(1'b1), "R2 keep running");
    drain();

    // R3: freeze on, stop at next boundary
    freeze_cfg = 1'b1;
    pulse_pd(p);
    push(bnd(p) - 1, 0, en_pat(1'b1), "R3 before boundary");
    push(bnd(p), 0, en_pat(1'b0), "R3 stop at boundary");
    push(bnd(p) + 20, 0, en_pat(1'b0), "R3 stays stopped");
    drain();

    // R6: auto wake on line activity
    autowake_off = 1'b0;
    pulse_line(p);
    push(bnd(p) - 1, 0, en_pat(1'b0), "R6 waits boundary");
    push(bnd(p), 0, en_pat(1'b1), "R6 restart");
    drain();

    // R8: activity while running sets nothing
    autowake_off = 1'b1;
    pulse_line(p);
    push(p + 2, 1, 4'b0000, "R8 no irq while running");
    drain();

    // R7: activity with auto wake disabled
    go_off("R3 stop again");
    pulse_line(p);
    push(p, 1, 4'b0001, "R7 irq set");
    push(bnd(p) + 1, 0, en_pat(1'b0), "R7 no restart");
    push(bnd(p) + 2, 1, 4'b0001, "R8 irq held");
    drain();
    @(negedge clk); irq_rd_clr = 1'b1; p = cyc + 1;
    @(negedge clk); irq_rd_clr = 1'b0;
    push(p + 1, 1, 4'b0000, "R8 irq cleared");
    drain();

    // R9: code write without sequence is ignored
    write_code(4'h0, p);
    push(bnd(p) + 1, 0, en_pat(1'b0), "R9 bare write ignored");
    drain();
    @(negedge clk); pwrup_bit = 1'b1;
    @(negedge clk); pwrup_bit = 1'b0;
    @(negedge clk);
    @(negedge clk);
    write_code(4'h3, p);
    push(bnd(p) + 1, 0, en_pat(1'b0), "R9 wrong code ignored");
    drain();
    write_code(4'h0, p);
    push(bnd(p) - 1, 0, en_pat(1'b0), "R9 waits boundary");
    push(bnd(p), 0, en_pat(1'b1), "R9 local wake");
    drain();

    // R10: clearing freeze wakes
    go_off("R3 stop third");
    @(negedge clk); freeze_cfg = 1'b0; p = cyc + 1;
    push(bnd(p), 0, en_pat(1'b1), "R10 freeze cleared wake");
    drain();

    // R10: clearing freeze cancels a pending stop
    freeze_cfg = 1'b1;
    while ((cyc % FRAME) != 2) @(negedge clk);
    pulse_pd(p);
    freeze_cfg = 1'b0;
    push(bnd(p) + 1, 0, en_pat(1'b1), "R10 pending cancelled");
    drain();

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule